// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of several localities owns a shared command interface. Each locality has its own address window, and the window number is taken from a field of the bus address. Within each window there is one access byte. Software uses it to ask for ownership, give ownership back, pre-empt a lower owner, and acknowledge that it was pre-empted. The arbiter holds the current owner. It also holds a pending next owner and the locality being aborted, for the time a hand-over must wait for a running command to stop.

When a hand-over would cut into a command that the command engine reports as busy, the arbiter raises a one-cycle cancel request. It then waits for the engine's abort-done strobe before it moves ownership. Every real change of owner produces a one-cycle change pulse, tagged with the new owner. The command data path and interrupt logic connect through these strobes and are not part of the block.

Top module: `loc_owner_arb`

## Requirements
- R1: The bus address splits into a locality field `bus_addr[OFS_W+LOC_W-1:OFS_W]` and an offset `bus_addr[OFS_W-1:0]`; the access byte sits at offset 0. After reset no locality owns the interface, and `owner` reads 7. An access-byte read for a locality below NUM_LOC returns bit 7 = 1, bit 6 = 0, and bit 0 = NOT `established`. Any other offset, or a locality field of NUM_LOC or above, reads 0xFF.
- R2: Writes addressed to the highest locality (NUM_LOC-1) change no state, although that locality's byte can still be read.
- R3: A write with bit 1 (request) set while no locality owns the interface makes the writer the owner. Its byte then reads bit 5 = 1.
- R4: A write with bit 1 set while a different locality owns the interface sets the writer's request flag, which reads back as bit 1.
- R5: Bit 2 of a locality's byte reads 1 exactly when some other locality has its request flag set. Bit 3 (the internal seize flag) always reads 0.
- R6: When the owner writes bit 5 = 1, ownership passes to the highest-numbered locality with a request flag set. If no locality has one, `owner` becomes 7.
- R7: When a locality that is not the owner writes bit 5 = 1, its own request flag is cleared and the owner is unchanged.
- R8: A write with bit 3 (seize) set is accepted only if no locality owns the interface or the writer's number is above the owner's. It is refused if the writer already has a seize pending or a higher locality has one. On acceptance, the seize flags of lower localities are dropped.
- R9: A write carrying bit 3 ignores the bit 1 and bit 5 values in the same byte.
- R10: On a change of owner, the old owner's bit 5 clears. After a seize, the old owner's bit 4 (seized) sets and its request flag is kept. After a release, its request flag clears instead. The new owner's request and seize flags clear.
- R11: Writing bit 4 = 1 clears the writer's seized flag.
- R12: If `cmd_busy` is high when a release or an accepted seize calls for a hand-over, `cancel_req` pulses for one cycle and the owner is held. The switch takes place on the cycle after `abort_done`. With `cmd_busy` low, the switch takes effect on the clock edge that registers the write.
- R13: `loc_chg` is high for exactly the one cycle after each change of `owner`, and `chg_tag` then equals the new owner. When `loc_chg` is low, `chg_tag` reads 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | OFS_W+LOC_W | Locality field above the register offset |
| bus_wdata | input | 8 | Write data for the access byte |
| rd_data | output | 8 | Combinational read of the addressed byte |
| established | input | 1 | Platform-established status; shown inverted in bit 0 |
| cmd_busy | input | 1 | Command engine is executing a command |
| abort_done | input | 1 | Command engine finished cancelling |
| owner | output | LOC_W | Current owner, 7 when none |
| loc_chg | output | 1 | One-cycle owner-change pulse |
| chg_tag | output | LOC_W | New owner during the pulse, else 7 |
| cancel_req | output | 1 | One-cycle cancel request to the command engine |

## Verification
The bench builds the block with five localities, a 3-bit locality field and a 4-bit offset. This keeps the address space small enough to reach out-of-range windows and unused offsets directly. With four writable localities, every subset of waiting requesters can be swept behind a releasing owner, and the bench derives each successor from the subset arithmetically. The deferred path is driven with the busy input held high so that refused re-seizes, cancel pulses and the late switch on abort-done can all be observed.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int ACC_W     = 8;
  localparam int B_VALID   = 7;
  localparam int B_ACTIVE  = 5;
  localparam int B_SEIZED  = 4;
  localparam int B_SEIZE   = 3;
  localparam int B_PEND    = 2;
  localparam int B_REQ     = 1;
  localparam int B_EST     = 0;
  typedef logic [ACC_W-1:0] acc_t;
  localparam acc_t NO_DATA = '1;
endpackage

// File: rtl/loc_addr_dec.sv
module loc_addr_dec #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3,
  parameter int OFS_W   = 12,
  localparam int ADDR_W = OFS_W + LOC_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LOC_W-1:0]  loc,
  output logic              loc_ok,
  output logic              is_acc
);
  assign loc    = addr[ADDR_W-1:OFS_W];
  assign loc_ok = (32'(loc) < NUM_LOC);
  assign is_acc = (addr[OFS_W-1:0] == '0);
endmodule

// File: rtl/loc_prio_pick.sv
module loc_prio_pick #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // a higher set bit overrides any lower one
  always_comb begin
    found = 1'b0;
    idx   = '1;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/loc_acc_view.sv
module loc_acc_view
  import loc_arb_pkg::*;
#(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [IW-1:0] loc,
  input  logic          loc_ok,
  input  logic          is_acc,
  input  logic [IW-1:0] own,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  bs,
  input  logic          established,
  output acc_t          val
);
  function automatic logic others_waiting(input logic [N-1:0] r, input logic [IW-1:0] me);
    return |(r & ~(N'(1) << me));
  endfunction

  always_comb begin
    val = NO_DATA;
    if (loc_ok && is_acc) begin
      val           = '0;
      val[B_VALID]  = 1'b1;
      val[B_ACTIVE] = (own == loc);
      val[B_SEIZED] = bs[loc];
      val[B_PEND]   = others_waiting(req, loc);
      val[B_REQ]    = req[loc];
      val[B_EST]    = ~established;
    end
  end
endmodule

// File: rtl/loc_owner_arb.sv
module loc_owner_arb
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3,
  parameter int OFS_W   = 12,
  localparam int ADDR_W = OFS_W + LOC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        rd_data,
  input  logic              established,
  input  logic              cmd_busy,
  input  logic              abort_done,
  output logic [LOC_W-1:0]  owner,
  output logic              loc_chg,
  output logic [LOC_W-1:0]  chg_tag,
  output logic              cancel_req
);
  localparam logic [LOC_W-1:0] NONE   = '1;
  localparam logic [LOC_W-1:0] HW_LOC = LOC_W'(NUM_LOC - 1);

  typedef struct packed {
    logic [NUM_LOC-1:0] req;
    logic [NUM_LOC-1:0] sz;
    logic [NUM_LOC-1:0] bs;
    logic [LOC_W-1:0]   own;
    logic [LOC_W-1:0]   nxt;
    logic [LOC_W-1:0]   abrt;
    logic               chg;
    logic               cancel;
  } st_t;

  // Hand ownership to tgt and update the flags of both parties.
  function automatic st_t do_switch(input st_t s, input logic [LOC_W-1:0] tgt);
    st_t  r;
    logic seized;
    r = s;
    if (tgt != s.own) begin
      seized = (tgt != NONE) && s.sz[tgt];
      if (s.own != NONE) begin
        if (seized) r.bs[s.own]  = 1'b1;
        else        r.req[s.own] = 1'b0;
      end
      r.chg = 1'b1;
    end
    r.own = tgt;
    if (tgt != NONE) begin
      r.req[tgt] = 1'b0;
      r.sz[tgt]  = 1'b0;
    end
    return r;
  endfunction

  // Start a hand-over; defer it behind a cancel when a command runs.
  function automatic st_t start_handover(input st_t s, input logic [LOC_W-1:0] from,
                                         input logic [LOC_W-1:0] tgt, input logic busy);
    st_t r;
    r      = s;
    r.abrt = from;
    r.nxt  = tgt;
    if (busy) begin
      r.cancel = 1'b1;
    end else begin
      r      = do_switch(r, tgt);
      r.nxt  = NONE;
      r.abrt = NONE;
    end
    return r;
  endfunction

  function automatic st_t apply_write(input st_t s, input logic [LOC_W-1:0] wl,
                                      input acc_t v, input logic busy,
                                      input logic pk_found, input logic [LOC_W-1:0] pk_idx);
    st_t              r;
    logic             seize_w, rel_w, req_w, keep, higher;
    logic [LOC_W-1:0] tgt;
    r       = s;
    seize_w = v[B_SEIZE];
    rel_w   = v[B_ACTIVE] & ~seize_w;
    req_w   = v[B_REQ] & ~seize_w;
    tgt     = s.own;
    keep    = 1'b1;
    higher  = 1'b0;
    if (rel_w) begin
      if (s.own == wl) begin
        if (pk_found) begin
          keep = 1'b0;
          r    = start_handover(r, wl, pk_idx, busy);
        end else begin
          tgt = NONE;
        end
      end else begin
        r.req[wl] = 1'b0;
      end
    end
    if (v[B_SEIZED]) r.bs[wl] = 1'b0;
    if (seize_w && (r.own == NONE || wl > r.own) && !r.sz[wl]) begin
      for (int i = 0; i < NUM_LOC; i++) begin
        if (i > int'(wl) && r.sz[i]) higher = 1'b1;
      end
      if (!higher) begin
        for (int i = 0; i < NUM_LOC; i++) begin
          if (i < int'(wl)) r.sz[i] = 1'b0;
        end
        r.sz[wl] = 1'b1;
        keep     = 1'b0;
        r        = start_handover(r, r.own, wl, busy);
      end
    end
    if (req_w && r.own != wl) begin
      if (r.own != NONE) r.req[wl] = 1'b1;
      else               tgt = wl;
    end
    if (keep) r = do_switch(r, tgt);
    return r;
  endfunction

  logic [LOC_W-1:0] a_loc;
  logic             a_ok;
  logic             a_acc;
  logic             wr_ok;
  logic             abort_wait;
  logic             pk_found;
  logic [LOC_W-1:0] pk_idx;
  st_t              st_q;
  st_t              st_a;
  st_t              st_b;

  loc_addr_dec #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .OFS_W(OFS_W)) u_dec (
    .addr(bus_addr), .loc(a_loc), .loc_ok(a_ok), .is_acc(a_acc)
  );

  assign wr_ok      = bus_wr && a_ok && a_acc && (a_loc != HW_LOC);
  assign abort_wait = (st_q.nxt != NONE);

  // stage A: completion of a deferred hand-over
  always_comb begin
    st_a        = st_q;
    st_a.chg    = 1'b0;
    st_a.cancel = 1'b0;
    if (abort_done && abort_wait) begin
      st_a      = do_switch(st_a, st_q.nxt);
      st_a.nxt  = NONE;
      st_a.abrt = NONE;
    end
  end

  loc_prio_pick #(.N(NUM_LOC), .IW(LOC_W)) u_pick (
    .vec(st_a.req), .found(pk_found), .idx(pk_idx)
  );

  // stage B: the bus write, seen after any completion
  always_comb begin
    st_b = st_a;
    if (wr_ok) st_b = apply_write(st_a, a_loc, acc_t'(bus_wdata), cmd_busy, pk_found, pk_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q.req    <= '0;
      st_q.sz     <= '0;
      st_q.bs     <= '0;
      st_q.own    <= NONE;
      st_q.nxt    <= NONE;
      st_q.abrt   <= NONE;
      st_q.chg    <= 1'b0;
      st_q.cancel <= 1'b0;
    end else begin
      st_q <= st_b;
    end
  end

  loc_acc_view #(.N(NUM_LOC), .IW(LOC_W)) u_view (
    .loc(a_loc), .loc_ok(a_ok), .is_acc(a_acc), .own(st_q.own),
    .req(st_q.req), .bs(st_q.bs), .established(established), .val(rd_data)
  );

  assign owner      = st_q.own;
  assign loc_chg    = st_q.chg;
  assign chg_tag    = st_q.chg ? st_q.own : NONE;
  assign cancel_req = st_q.cancel;
endmodule

// File: rtl/loc_owner_arb_chk.sv
module loc_owner_arb_chk #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3,
  parameter int OFS_W   = 12,
  localparam int ADDR_W = OFS_W + LOC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        rd_data,
  input logic              cmd_busy,
  input logic [LOC_W-1:0]  owner,
  input logic              loc_chg,
  input logic [LOC_W-1:0]  chg_tag,
  input logic              cancel_req,
  input logic              abort_wait
);
  localparam logic [LOC_W-1:0] NONE   = '1;
  localparam logic [LOC_W-1:0] HW_LOC = LOC_W'(NUM_LOC - 1);

  logic [LOC_W-1:0] f_loc;
  logic             f_acc;
  assign f_loc = bus_addr[ADDR_W-1:OFS_W];
  assign f_acc = (bus_addr[OFS_W-1:0] == '0);

  // R2
  hw_loc_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && f_acc && f_loc == HW_LOC && !abort_wait) |=> $stable(owner));

  // R1
  valid_bit_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_acc && 32'(f_loc) < NUM_LOC) |-> (rd_data[7] && !rd_data[6]));

  // R5
  seize_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_acc && 32'(f_loc) < NUM_LOC) |-> !rd_data[3]);

  // R13
  change_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner != $past(owner)) |-> loc_chg);

  // R13
  change_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_chg |-> (chg_tag == owner));

  // R12
  cancel_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_req |-> $past(cmd_busy));

  // R1
  owner_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(owner) < NUM_LOC) || (owner == NONE));
endmodule

bind loc_owner_arb loc_owner_arb_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .OFS_W(OFS_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .rd_data(rd_data),
  .cmd_busy(cmd_busy), .owner(owner), .loc_chg(loc_chg), .chg_tag(chg_tag),
  .cancel_req(cancel_req), .abort_wait(abort_wait)
);

// File: tb/test_loc_owner_arb.sv
module test_loc_owner_arb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_LOC = 5;
  localparam int LOC_W   = 3;
  localparam int OFS_W   = 4;
  localparam int ADDR_W  = OFS_W + LOC_W;
  localparam int NONE    = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0]        bus_wdata = '0;
  logic [7:0]        rd_data;
  logic              established = 1'b0;
  logic              cmd_busy = 1'b0;
  logic              abort_done = 1'b0;
  logic [LOC_W-1:0]  owner;
  logic              loc_chg;
  logic [LOC_W-1:0]  chg_tag;
  logic              cancel_req;

  int n_chk = 0;
  int n_err = 0;

  loc_owner_arb #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .OFS_W(OFS_W)) i_loc_owner_arb (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .established(established), .cmd_busy(cmd_busy),
    .abort_done(abort_done), .owner(owner), .loc_chg(loc_chg), .chg_tag(chg_tag),
    .cancel_req(cancel_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int loc, input int v);
    @(negedge clk);
    bus_addr  = {LOC_W'(loc), OFS_W'(0)};
    bus_wdata = 8'(v);
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int loc, input int ofs, input int exp);
    bus_addr = {LOC_W'(loc), OFS_W'(ofs)};
    #1;
    check(tag, int'(rd_data), exp);
  endtask

  task automatic done_pulse;
    @(negedge clk);
    abort_done = 1'b1;
    @(negedge clk);
    abort_done = 1'b0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int rem;
    int cur;
    int expn;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and read decode
    check("R1 owner after reset", int'(owner), NONE);
    for (int k = 0; k < NUM_LOC; k++) rd_chk("R1 reset byte", k, 0, 8'h81);
    rd_chk("R1 other offset", 1, 4, 8'hFF);
    for (int k = NUM_LOC; k < 8; k++) rd_chk("R1 out-of-range locality", k, 0, 8'hFF);
    established = 1'b1;
    rd_chk("R1 established bit", 0, 0, 8'h80);
    established = 1'b0;

    // R2 top locality writes ignored
    wr(4, 8'h02);
    check("R2 request ignored", int'(owner), NONE);
    wr(4, 8'h08);
    check("R2 seize ignored", int'(owner), NONE);
    rd_chk("R2 byte unchanged", 4, 0, 8'h81);

    // R3 R6 R13 sweep: each writable locality takes and gives back ownership
    for (int l = 0; l < NUM_LOC - 1; l++) begin
      wr(l, 8'h02);
      check("R3 owner taken", int'(owner), l);
      check("R13 pulse", int'(loc_chg), 1);
      check("R13 tag", int'(chg_tag), l);
      for (int k = 0; k < NUM_LOC; k++)
        rd_chk("R3 active bit", k, 0, 8'h81 | ((k == l) ? 8'h20 : 8'h00));
      wr(l, 8'h20);
      check("R6 released to none", int'(owner), NONE);
      check("R13 tag none", int'(chg_tag), NONE);
      @(negedge clk);
      check("R13 pulse one cycle", int'(loc_chg), 0);
    end

    // R4 R5 requests while owned
    wr(1, 8'h02);
    wr(0, 8'h02);
    rd_chk("R4 request flag", 0, 0, 8'h83);
    rd_chk("R5 pending at owner", 1, 0, 8'hA5);
    rd_chk("R5 pending at idle", 2, 0, 8'h85);
    wr(3, 8'h02);
    rd_chk("R5 pending with own request", 3, 0, 8'h87);

    // R6 release picks highest requester
    wr(1, 8'h20);
    check("R6 highest requester", int'(owner), 3);
    rd_chk("R6 new owner byte", 3, 0, 8'hA5);
    rd_chk("R6 old owner byte", 1, 0, 8'h85);

    // R7 non-owner drop of its request
    wr(0, 8'h20);
    rd_chk("R7 request cleared", 0, 0, 8'h81);
    check("R7 owner kept", int'(owner), 3);
    check("R7 no change", int'(loc_chg), 0);
    wr(3, 8'h20);
    check("R6 no requester", int'(owner), NONE);

    // R6 subset sweep: owner 0, requesters among 1..3, cascade of releases
    for (int m = 0; m < 8; m++) begin
      wr(0, 8'h02);
      for (int b = 1; b < 4; b++) if (m[b-1]) wr(b, 8'h02);
      cur = 0;
      rem = m << 1;
      for (int step = 0; step < 4; step++) begin
        wr(cur, 8'h20);
        expn = NONE;
        for (int b = 0; b < 4; b++) if (rem[b]) expn = b;
        check("R6 cascade owner", int'(owner), expn);
        if (expn == NONE) break;
        rem = rem & ~(1 << expn);
        cur = expn;
      end
    end

    // R8 refused lower seize
    wr(2, 8'h02);
    check("R3 owner 2", int'(owner), 2);
    wr(1, 8'h08);
    check("R8 lower seize refused", int'(owner), 2);
    check("R8 no cancel", int'(cancel_req), 0);
    // R9 seize write ignores request bit
    wr(1, 8'h0A);
    rd_chk("R9 request ignored", 1, 0, 8'h81);
    // R8 R10 accepted seize, active bit in same write ignored
    wr(3, 8'h2A);
    check("R8 seize accepted", int'(owner), 3);
    check("R13 seize pulse", int'(chg_tag), 3);
    rd_chk("R10 seized flag", 2, 0, 8'h91);
    rd_chk("R10 new owner byte", 3, 0, 8'hA1);
    // R11 clear seized flag
    wr(2, 8'h10);
    rd_chk("R11 seized cleared", 2, 0, 8'h81);

    // R12 deferred release
    wr(0, 8'h02);
    cmd_busy = 1'b1;
    wr(3, 8'h20);
    check("R12 cancel on release", int'(cancel_req), 1);
    check("R12 owner held", int'(owner), 3);
    check("R12 no change yet", int'(loc_chg), 0);
    @(negedge clk);
    check("R12 cancel one cycle", int'(cancel_req), 0);
    done_pulse();
    check("R12 switch on done", int'(owner), 0);
    check("R13 deferred tag", int'(chg_tag), 0);
    rd_chk("R10 released owner clean", 3, 0, 8'h81);

    // R12 R8 deferred seize and refused repeats
    wr(2, 8'h08);
    check("R12 cancel on seize", int'(cancel_req), 1);
    check("R12 owner held on seize", int'(owner), 0);
    wr(2, 8'h08);
    check("R8 repeat seize refused", int'(cancel_req), 0);
    wr(1, 8'h08);
    check("R8 seize under higher refused", int'(cancel_req), 0);
    done_pulse();
    check("R12 seize completes", int'(owner), 2);
    rd_chk("R10 deferred seized flag", 0, 0, 8'h91);
    rd_chk("R5 seize hidden", 1, 0, 8'h81);
    cmd_busy = 1'b0;

    // R8 seize with nobody active
    wr(2, 8'h20);
    check("R6 back to none", int'(owner), NONE);
    wr(1, 8'h08);
    check("R8 seize from none", int'(owner), 1);
    check("R13 seize from none pulse", int'(loc_chg), 1);
    wr(4, 8'h28);
    check("R2 top seize ignored", int'(owner), 1);

    summary();
    $finish;
  end
endmodule